// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Controller

The block gathers up to 32 interrupt sources into two request lines to a processor: one for ordinary (non-critical) interrupts and one for critical interrupts. Each source is first brought to a common sense through a per-source polarity bit. Its trigger bit then decides whether a request is latched while the conditioned input is active (level) or only on its transition to active (edge). Latched requests sit in a status register until software clears them by writing ones.

An enable register decides which latched requests may reach the outputs. A routing register sends each source to either the critical or the non-critical line. A read-only view returns status ANDed with enable. All registers share a single-cycle port with a write strobe, a 3-bit address and a combinational read. Instances can be cascaded: the non-critical output of a subordinate instance drives an ordinary input of a base instance that is set to level sensing.

Top module: `intc32`

## Requirements
- R1: Source n (input bit `src_i[n]`) is held at register bit 31-n in every register, so source 0 is bit 31.
- R2: While reset is asserted, every register reads zero and both outputs are low.
- R3: Status (address 0) is write-one-to-clear: a 1 in the written data clears that bit, a 0 leaves it unchanged, and a status bit never clears by any other means.
- R4: When trigger bit is 0 (level), a status bit is set at every clock edge where the conditioned input is active. Polarity bit 1 means active-high and 0 means active-low. A bit cleared while its input is still active is set again.
- R5: When trigger bit is 1 (edge), a status bit is set at the clock edge after the conditioned input goes from inactive to active. Polarity 1 selects a rising edge and 0 a falling edge. The bit stays set after the input returns to inactive, and the return transition sets nothing.
- R6: If a clearing write and a new assertion reach the same status bit in the same cycle, the bit stays set.
- R7: Enable (address 1) gates the outputs: a status bit with a 0 enable drives no output, and clearing an enable bit leaves the status bit unchanged.
- R8: Routing (address 2): an enabled set status bit drives `irq_crit_o` when its routing bit is 1 and `irq_nc_o` when it is 0. All zeros means the critical line stays low.
- R9: Address 5 reads status AND enable. Writes to it change no register.
- R10: Enable, routing, trigger (address 3) and polarity (address 4) read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt inputs, bit n is source n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_nc_o | output | 1 | Non-critical interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
Each of the 32 sources is raised on its own, first in level mode and then in edge mode. In edge mode the polarity pattern mixes rising and falling sources, so a single-bit result exposes any error in source-to-bit mapping or polarity inversion. In level mode, clearing the bit while the input is still held separates level behaviour from edge behaviour. In edge mode, returning the input to inactive and then clearing separates latching from level-following. Two sources with different routing are swept through enable settings to tell the critical line from the non-critical line, and to show that masking is separate from status. A clear that coincides with a new edge checks the set-over-clear priority.

// File: rtl/intc32_pkg.sv
package intc32_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CRIT = 3'd2;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd3;
  localparam logic [ADDR_W-1:0] A_POL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_MSK  = 3'd5;
endpackage

// File: rtl/intc32_sense.sv
module intc32_sense #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_bits_i,
  input  logic [N_SRC-1:0] trig_i,
  input  logic [N_SRC-1:0] pol_i,
  output logic [N_SRC-1:0] hit_o
);
  logic [N_SRC-1:0] act;
  logic [N_SRC-1:0] act_q;

  for (genvar b = 0; b < N_SRC; b++) begin : g_bit
    assign act[b]   = pol_i[b] ? src_bits_i[b] : ~src_bits_i[b];
    assign hit_o[b] = trig_i[b] ? (act[b] & ~act_q[b]) : act[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act;
  end
endmodule

// File: rtl/intc32_regs.sv
module intc32_regs
  import intc32_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic [N_SRC-1:0]  hit_i,
  output logic [N_SRC-1:0]  stat_o,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  crit_o,
  output logic [N_SRC-1:0]  trig_o,
  output logic [N_SRC-1:0]  pol_o
);
  logic [N_SRC-1:0] clr;
  assign clr = (wr_en_i && addr_i == A_STAT) ? wdata_i : '0;

  // new assertion wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~clr) | hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      crit_o <= '0;
      trig_o <= '0;
      pol_o  <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_EN:    en_o   <= wdata_i;
        A_CRIT:  crit_o <= wdata_i;
        A_TRIG:  trig_o <= wdata_i;
        A_POL:   pol_o  <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/intc32_route.sv
module intc32_route #(
  parameter int unsigned N_SRC = 32
) (
  input  logic [N_SRC-1:0] stat_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] crit_i,
  output logic [N_SRC-1:0] masked_o,
  output logic             irq_nc_o,
  output logic             irq_crit_o
);
  assign masked_o   = stat_i & en_i;
  assign irq_nc_o   = |(masked_o & ~crit_i);
  assign irq_crit_o = |(masked_o & crit_i);
endmodule

// File: rtl/intc32.sv
module intc32
  import intc32_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              irq_nc_o,
  output logic              irq_crit_o
);
  localparam int unsigned MSB = N_SRC - 1;

  logic [N_SRC-1:0] src_bits, hit, masked;
  logic [N_SRC-1:0] stat_q, en_q, crit_q, trig_q, pol_q;

  // source n lives at register bit MSB-n
  for (genvar n = 0; n < N_SRC; n++) begin : g_map
    assign src_bits[MSB-n] = src_i[n];
  end

  intc32_sense #(.N_SRC(N_SRC)) u_sense (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_bits_i (src_bits),
    .trig_i     (trig_q),
    .pol_i      (pol_q),
    .hit_o      (hit)
  );

  intc32_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .hit_i   (hit),
    .stat_o  (stat_q),
    .en_o    (en_q),
    .crit_o  (crit_q),
    .trig_o  (trig_q),
    .pol_o   (pol_q)
  );

  intc32_route #(.N_SRC(N_SRC)) u_route (
    .stat_i     (stat_q),
    .en_i       (en_q),
    .crit_i     (crit_q),
    .masked_o   (masked),
    .irq_nc_o   (irq_nc_o),
    .irq_crit_o (irq_crit_o)
  );

  always_comb begin
    unique case (addr_i)
      A_STAT:  rdata_o = stat_q;
      A_EN:    rdata_o = en_q;
      A_CRIT:  rdata_o = crit_q;
      A_TRIG:  rdata_o = trig_q;
      A_POL:   rdata_o = pol_q;
      A_MSK:   rdata_o = masked;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intc32_chk.sv
module intc32_chk
  import intc32_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  src_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_SRC-1:0]  wdata_i,
  input logic              irq_nc_o,
  input logic              irq_crit_o,
  input logic [N_SRC-1:0]  stat_q,
  input logic [N_SRC-1:0]  en_q,
  input logic [N_SRC-1:0]  crit_q,
  input logic [N_SRC-1:0]  trig_q,
  input logic [N_SRC-1:0]  pol_q
);
  logic             armed_q;
  logic [N_SRC-1:0] lvl_req, clr_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  always_comb begin
    for (int n = 0; n < N_SRC; n++)
      lvl_req[N_SRC-1-n] = ~trig_q[N_SRC-1-n] & ~(src_i[n] ^ pol_q[N_SRC-1-n]);
  end
  assign clr_req = (wr_en_i && addr_i == A_STAT) ? wdata_i : '0;

  p_only_w1c_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (($past(stat_q) & ~$past(clr_req) & ~stat_q) == '0));

  p_level_latches_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (($past(lvl_req) & ~stat_q) == '0));

  p_disabled_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> (!irq_nc_o && !irq_crit_o));

  p_no_crit_route_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_q == '0) |-> !irq_crit_o);

  p_masked_read_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MSK) |=>
      ($stable(en_q) && $stable(crit_q) && $stable(trig_q) && $stable(pol_q)));
endmodule

bind intc32 intc32_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (src_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .irq_nc_o   (irq_nc_o),
  .irq_crit_o (irq_crit_o),
  .stat_q     (stat_q),
  .en_q       (en_q),
  .crit_q     (crit_q),
  .trig_q     (trig_q),
  .pol_q      (pol_q)
);

// File: tb/intc32_test.sv
`timescale 1ns/1ps
module intc32_test;
  import intc32_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '1;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_nc_o, irq_crit_o;

  int vecs = 0;
  int errs = 0;

  always #4 clk_i = ~clk_i;

  intc32 uut (.*);

  function automatic logic [31:0] rev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    addr_i = a;
    #1;
    vecs++;
    if (rdata_o !== exp) begin
      errs++;
      $display("FAIL %s addr=%0d got=%h exp=%h", tag, a, rdata_o, exp);
    end
  endtask

  task automatic chk_irq(input logic crit, input logic nc, input string tag);
    #1;
    vecs++;
    if ({irq_crit_o, irq_nc_o} !== {crit, nc}) begin
      errs++;
      $display("FAIL %s crit/nc got=%b%b exp=%b%b", tag, irq_crit_o, irq_nc_o, crit, nc);
    end
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] polx;
    logic [31:0] base;
    // R2: reset state
    repeat (2) tick();
    for (int a = 0; a < 6; a++) chk(3'(a), 32'h0, "R2 reset");
    chk_irq(1'b0, 1'b0, "R2 reset");
    rst_ni = 1'b1;
    repeat (2) tick();
    chk(A_STAT, 32'h0, "R4 inactive low-sense");

    // R10 readback, R9 masked is read-only
    wr(A_EN, 32'h1234_5678);  chk(A_EN, 32'h1234_5678, "R10 en");
    wr(A_CRIT, 32'h8765_4321); chk(A_CRIT, 32'h8765_4321, "R10 crit");
    wr(A_TRIG, 32'hDEAD_BEEF); chk(A_TRIG, 32'hDEAD_BEEF, "R10 trig");
    wr(A_POL, 32'hFFFF_FFFF); chk(A_POL, 32'hFFFF_FFFF, "R10 pol");
    wr(A_MSK, 32'hFFFF_FFFF);
    chk(A_EN, 32'h1234_5678, "R9 masked write ignored");
    chk(A_CRIT, 32'h8765_4321, "R9 masked write ignored");
    chk(A_TRIG, 32'hDEAD_BEEF, "R9 masked write ignored");

    // level sweep: pol all high, trig level, enable off
    wr(A_EN, '0); wr(A_CRIT, '0); wr(A_TRIG, '0);
    src_i = '0;
    wr(A_STAT, '1);
    chk(A_STAT, 32'h0, "R3 clear all");
    for (int n = 0; n < 32; n++) begin
      src_i = 32'h1 << n;
      tick();
      chk(A_STAT, 32'h1 << (31 - n), "R1 R4 level set");
      wr(A_STAT, 32'h1 << (31 - n));
      chk(A_STAT, 32'h1 << (31 - n), "R4 re-set while active");
      wr(A_STAT, 32'h0);
      chk(A_STAT, 32'h1 << (31 - n), "R3 zero write no effect");
      src_i = '0;
      wr(A_STAT, 32'h1 << (31 - n));
      chk(A_STAT, 32'h0, "R3 w1c clears");
    end

    // edge sweep with mixed polarity
    polx = 32'hAAAA_5555;
    base = rev(~polx);
    src_i = base;
    wr(A_POL, polx);
    wr(A_TRIG, '1);
    tick();
    wr(A_STAT, '1);
    chk(A_STAT, 32'h0, "R5 idle edge");
    for (int n = 0; n < 32; n++) begin
      src_i = base ^ (32'h1 << n);
      tick();
      chk(A_STAT, 32'h1 << (31 - n), "R1 R5 edge set");
      src_i = base;
      tick();
      chk(A_STAT, 32'h1 << (31 - n), "R5 held after return");
      wr(A_STAT, 32'h1 << (31 - n));
      tick();
      chk(A_STAT, 32'h0, "R5 return edge ignored");
    end

    // R6: clear and new edge in the same cycle
    src_i = base ^ 32'h8;
    tick();
    src_i = base;
    tick();
    chk(A_STAT, 32'h1 << 28, "R6 pre-set");
    @(negedge clk_i);
    src_i = base ^ 32'h8;
    wr_en_i = 1'b1; addr_i = A_STAT; wdata_i = 32'h1 << 28;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk(A_STAT, 32'h1 << 28, "R6 set wins over clear");
    src_i = base;
    wr(A_STAT, '1);

    // R7/R8: sources 0 and 5 latched in level mode
    wr(A_POL, '1); wr(A_TRIG, '0);
    src_i = 32'h21;
    tick();
    src_i = '0;
    tick();
    wr(A_STAT, ~32'h8400_0000);
    chk(A_STAT, 32'h8400_0000, "R7 setup");
    chk_irq(1'b0, 1'b0, "R7 all disabled");
    wr(A_EN, 32'h8400_0000);
    chk_irq(1'b0, 1'b1, "R8 zero routing to nc");
    chk(A_MSK, 32'h8400_0000, "R9 masked");
    wr(A_CRIT, 32'h8000_0000);
    chk_irq(1'b1, 1'b1, "R8 split routing");
    wr(A_EN, 32'h8000_0000);
    chk_irq(1'b1, 1'b0, "R8 crit only");
    chk(A_MSK, 32'h8000_0000, "R9 masked partial");
    wr(A_EN, 32'h0);
    chk_irq(1'b0, 1'b0, "R7 disabled");
    chk(A_STAT, 32'h8400_0000, "R7 status kept");
    chk(A_MSK, 32'h0, "R9 masked zero");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule